// File: doc/BRIEF.md
# DSP Data Address Generator

The block produces data-memory addresses for a signal-processing datapath. It holds eight register sets. Each set has an index, a modifier, a length and a base, and there is a second copy of every set. A mode input picks which copy serves accesses. Software-side loads of any register arrive through a single write port.

On each access request the generator returns an address one cycle later. The access names one index register. The offset is taken from a modifier register or from an immediate.

- In offset mode, the address is index plus offset and the index is left alone.
- In post-update mode, the address is the index itself, and the index is then advanced.
- The advance is linear when the set's length is zero. With a non-zero length it wraps inside a circular buffer. With bit-reverse enabled it steps in bit-reversed order over the low index bits.

Top module: `dag`

## Requirements
- R1: After reset every index, modifier, length and base register in both banks is zero, and `addr` and `addr_valid` are zero.
- R2: When `wr_en` is high, the register chosen by `wr_kind` (0 index, 1 modifier, 2 length, 3 base), `wr_sel` and `wr_alt` (0 primary, 1 alternate bank) takes `wr_data` at the clock edge.
- R3: `addr_valid` equals `req` of the previous cycle. In a cycle after no request, `addr` keeps its last value.
- R4: A post-update access (`pre_mode`=0) returns the current index as `addr`. When the set's length is zero and `brev_en`=0, the index then becomes index plus offset, modulo 2^AW.
- R5: The offset is `imm` when `use_imm`=1, else modifier register `mod_sel` of the active bank. The offset is read as a two's-complement value.
- R6: An offset access (`pre_mode`=1) returns index plus offset, modulo 2^AW, and leaves the index unchanged.
- R7: In a post-update access with non-zero length L and base B, the sum index plus offset has L subtracted if it is above B+L-1, and L added if it is below B. This keeps any in-range index inside B..B+L-1 for offsets of magnitude up to L.
- R8: With `brev_en`=1, a post-update access sets the low BRW index bits to reverse(reverse(index low bits) + offset low bits) over BRW bits. The upper bits are kept. Bit-reverse takes precedence over circular wrap.
- R9: `alt_bank` selects the bank for the index, modifier, length and base read by an access and for the index it updates. The other bank's registers are not changed.
- R10: When the write port and an update target the same index register in the same cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_alt | input | 1 | Bank for the write |
| wr_kind | input | 2 | Register kind for the write |
| wr_sel | input | 3 | Set number for the write |
| wr_data | input | AW | Write value |
| alt_bank | input | 1 | Active bank for accesses |
| req | input | 1 | Access request |
| req_sel | input | 3 | Set whose index, length and base are used |
| mod_sel | input | 3 | Modifier register used as offset |
| use_imm | input | 1 | Take the offset from `imm` |
| imm | input | AW | Immediate offset |
| pre_mode | input | 1 | Offset access without update |
| brev_en | input | 1 | Bit-reversed update |
| addr | output | AW | Generated address |
| addr_valid | output | 1 | Address valid, one cycle after `req` |

## Verification
A wrong index update stays hidden until the same set is accessed again. The next access then returns a wrong `addr` one cycle after its request. For this reason the stimulus repeatedly re-accesses each set, and every cycle is compared against a behavioural model. A wrong bank selection or a lost write shows up the same way, on the first access that reads the affected register. Errors in the circular wrap and in the bit-reverse stepping appear within a few accesses because the sequences are chosen to cross the buffer ends and the reversed carry chain.

// File: rtl/dag.sv
module dag #(
  parameter int AW   = 16,
  parameter int NSET = 8,
  parameter int BRW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_alt,
  input  logic [1:0]              wr_kind,
  input  logic [$clog2(NSET)-1:0] wr_sel,
  input  logic [AW-1:0]           wr_data,
  input  logic                    alt_bank,
  input  logic                    req,
  input  logic [$clog2(NSET)-1:0] req_sel,
  input  logic [$clog2(NSET)-1:0] mod_sel,
  input  logic                    use_imm,
  input  logic [AW-1:0]           imm,
  input  logic                    pre_mode,
  input  logic                    brev_en,
  output logic [AW-1:0]           addr,
  output logic                    addr_valid
);
  localparam logic [AW-1:0] BMASK = AW'((64'd1 << BRW) - 64'd1);

  logic [AW-1:0] ireg [2][NSET];
  logic [AW-1:0] mreg [2][NSET];
  logic [AW-1:0] lreg [2][NSET];
  logic [AW-1:0] breg [2][NSET];

  logic [AW-1:0] cur_i, cur_l, cur_b, mod, sum, nxt_idx, brev_idx;
  logic signed [AW+1:0] s_ext, lo_lim, hi_lim, len_ext, wrapped;
  logic [BRW-1:0] rev_sum;
  logic upd_en;

  function automatic logic [BRW-1:0] flip(input logic [BRW-1:0] v);
    for (int k = 0; k < BRW; k++) flip[k] = v[BRW-1-k];
  endfunction

  assign cur_i  = ireg[alt_bank][req_sel];
  assign cur_l  = lreg[alt_bank][req_sel];
  assign cur_b  = breg[alt_bank][req_sel];
  assign mod    = use_imm ? imm : mreg[alt_bank][mod_sel];
  assign sum    = cur_i + mod;
  assign upd_en = req & ~pre_mode;

  assign s_ext   = $signed({2'b00, cur_i}) + $signed({{2{mod[AW-1]}}, mod});
  assign len_ext = $signed({2'b00, cur_l});
  assign lo_lim  = $signed({2'b00, cur_b});
  assign hi_lim  = lo_lim + len_ext;
  assign wrapped = (s_ext >= hi_lim) ? s_ext - len_ext :
                   (s_ext < lo_lim)  ? s_ext + len_ext : s_ext;

  assign rev_sum  = flip(flip(cur_i[BRW-1:0]) + mod[BRW-1:0]);
  assign brev_idx = (cur_i & ~BMASK) | AW'(rev_sum);

  always_comb begin
    if (brev_en)          nxt_idx = brev_idx;
    else if (cur_l == '0) nxt_idx = sum;
    else                  nxt_idx = wrapped[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NSET; s++) begin
          ireg[b][s] <= '0;
          mreg[b][s] <= '0;
          lreg[b][s] <= '0;
          breg[b][s] <= '0;
        end
      addr       <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req;
      if (req) addr <= pre_mode ? sum : cur_i;
      if (upd_en) ireg[alt_bank][req_sel] <= nxt_idx;
      if (wr_en) begin
        case (wr_kind)
          2'd0: ireg[wr_alt][wr_sel] <= wr_data;
          2'd1: mreg[wr_alt][wr_sel] <= wr_data;
          2'd2: lreg[wr_alt][wr_sel] <= wr_data;
          default: breg[wr_alt][wr_sel] <= wr_data;
        endcase
      end
    end
  end
endmodule

module dag_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          pre_mode,
  input logic          brev_en,
  input logic          upd_en,
  input logic [AW-1:0] cur_i,
  input logic [AW-1:0] cur_l,
  input logic [AW-1:0] cur_b,
  input logic [AW-1:0] mod,
  input logic [AW-1:0] nxt_idx,
  input logic [AW-1:0] addr,
  input logic          addr_valid
);
  logic [AW:0] top, mag;
  logic        circ_ok;
  assign top = {1'b0, cur_b} + {1'b0, cur_l};
  assign mag = mod[AW-1] ? {1'b0, -mod} : {1'b0, mod};
  assign circ_ok = upd_en && !brev_en && cur_l != '0 && {1'b0, cur_i} >= {1'b0, cur_b}
                   && {1'b0, cur_i} < top && mag <= {1'b0, cur_l} && top <= (1 << AW);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req |=> addr_valid); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !req |=> (!addr_valid && $stable(addr))); // R3
  AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (req && !pre_mode) |=> addr == $past(cur_i)); // R4
  AST_PRE_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (req && pre_mode) |=> addr == $past(cur_i + mod)); // R6
  AST_CIRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n) circ_ok |-> ({1'b0, nxt_idx} >= {1'b0, cur_b} && {1'b0, nxt_idx} < top)); // R7
endmodule

bind dag dag_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .pre_mode(pre_mode), .brev_en(brev_en),
  .upd_en(upd_en), .cur_i(cur_i), .cur_l(cur_l), .cur_b(cur_b), .mod(mod),
  .nxt_idx(nxt_idx), .addr(addr), .addr_valid(addr_valid)
);

// File: tb/dag_test.sv
module dag_test;
  localparam int AW = 16, NSET = 8, BRW = 8;
  localparam int AMASK = (1 << AW) - 1, BMSK = (1 << BRW) - 1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_alt = 0;
  logic [1:0] wr_kind = 0;
  logic [2:0] wr_sel = 0, req_sel = 0, mod_sel = 0;
  logic [AW-1:0] wr_data = 0, imm = 0;
  logic alt_bank = 0, req = 0, use_imm = 0, pre_mode = 0, brev_en = 0;
  logic [AW-1:0] addr;
  logic addr_valid;

  dag #(.AW(AW), .NSET(NSET), .BRW(BRW)) uut (
    .clk, .rst_n, .wr_en, .wr_alt, .wr_kind, .wr_sel, .wr_data, .alt_bank,
    .req, .req_sel, .mod_sel, .use_imm, .imm, .pre_mode, .brev_en, .addr, .addr_valid
  );

  always #5 clk = ~clk;

  int mi [2][NSET], mm [2][NSET], ml [2][NSET], mb [2][NSET];
  int ea = 0, ev = 0, checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  function automatic int rv(int v);
    int r = 0;
    for (int k = 0; k < BRW; k++) if (v[k]) r |= 1 << (BRW - 1 - k);
    return r;
  endfunction

  always @(posedge clk) begin
    int b, s, ci, m, nx, lo;
    if (!rst_n) begin
      for (int x = 0; x < 2; x++)
        for (int y = 0; y < NSET; y++) begin mi[x][y] = 0; mm[x][y] = 0; ml[x][y] = 0; mb[x][y] = 0; end
      ea = 0; ev = 0;
    end else begin
      b = int'(alt_bank); s = int'(req_sel); ci = mi[b][s];
      m = use_imm ? int'(imm) : mm[b][mod_sel];
      if (m > AMASK / 2) m = m - (1 << AW);
      ev = int'(req);
      if (req) begin
        if (pre_mode) ea = (ci + m) & AMASK;
        else begin
          ea = ci;
          if (brev_en) begin
            lo = rv((rv(ci & BMSK) + m) & BMSK);
            nx = (ci & ~BMSK) | lo;
          end else if (ml[b][s] == 0) nx = (ci + m) & AMASK;
          else begin
            nx = ci + m;
            if (nx > mb[b][s] + ml[b][s] - 1) nx = nx - ml[b][s];
            else if (nx < mb[b][s]) nx = nx + ml[b][s];
            nx = nx & AMASK;
          end
          mi[b][s] = nx;
        end
      end
      if (wr_en)
        case (wr_kind)
          2'd0: mi[wr_alt][wr_sel] = int'(wr_data);
          2'd1: mm[wr_alt][wr_sel] = int'(wr_data);
          2'd2: ml[wr_alt][wr_sel] = int'(wr_data);
          default: mb[wr_alt][wr_sel] = int'(wr_data);
        endcase
    end
  end

  task automatic tick();
    @(negedge clk);
    checks++;
    if (int'(addr_valid) !== ev || int'(addr) !== ea) begin
      errors++;
      $display("FAIL %s: addr=%h valid=%0d expected addr=%h valid=%0d", tag, addr, addr_valid, ea[AW-1:0], ev);
    end
    wr_en = 0; req = 0;
  endtask

  task automatic wr(input bit alt, input int kind, input int sel, input int val);
    wr_en = 1; wr_alt = alt; wr_kind = 2'(kind); wr_sel = 3'(sel); wr_data = AW'(val);
    tick();
  endtask

  task automatic acc(input bit alt, input int sel, input int msel, input bit ui, input int iv,
                     input bit pre, input bit br);
    req = 1; alt_bank = alt; req_sel = 3'(sel); mod_sel = 3'(msel); use_imm = ui;
    imm = AW'(iv); pre_mode = pre; brev_en = br;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; tick(); tick();
    tag = "R2"; wr(0, 0, 0, 100); wr(0, 1, 0, 4);
    tag = "R4"; for (int k = 0; k < 3; k++) acc(0, 0, 0, 0, 0, 0, 0);
    tag = "R3"; tick(); tick();
    tag = "R5"; acc(0, 0, 0, 1, -3, 0, 0); acc(0, 0, 0, 1, -3, 0, 0); acc(0, 0, 3, 0, 0, 0, 0);
    tag = "R6"; acc(0, 0, 0, 1, 10, 1, 0); acc(0, 0, 0, 0, 0, 1, 0); acc(0, 0, 0, 0, 0, 0, 0);
    tag = "R7"; wr(0, 0, 1, 'h40); wr(0, 3, 1, 'h40); wr(0, 2, 1, 5); wr(0, 1, 1, 2);
    for (int k = 0; k < 7; k++) acc(0, 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) acc(0, 1, 1, 1, -3, 0, 0);
    acc(0, 1, 1, 1, 5, 0, 0); acc(0, 1, 1, 1, -5, 0, 0); acc(0, 1, 1, 0, 0, 0, 0);
    tag = "R8"; wr(0, 0, 2, 'h1200); wr(0, 2, 2, 3); wr(0, 3, 2, 'h1200);
    for (int k = 0; k < 10; k++) acc(0, 2, 0, 1, 'h80, 0, 1);
    wr(0, 0, 3, 'h34FE); for (int k = 0; k < 4; k++) acc(0, 3, 0, 1, 'h40, 0, 1);
    tag = "R9"; wr(1, 0, 0, 500); wr(1, 1, 0, 7);
    for (int k = 0; k < 3; k++) acc(1, 0, 0, 0, 0, 0, 0);
    acc(0, 0, 0, 0, 0, 0, 0); acc(0, 0, 0, 0, 0, 0, 0); acc(1, 0, 0, 0, 0, 0, 0);
    tag = "R10";
    wr_en = 1; wr_alt = 0; wr_kind = 0; wr_sel = 0; wr_data = 7;
    acc(0, 0, 0, 0, 0, 0, 0); acc(0, 0, 0, 0, 0, 0, 0); acc(0, 0, 0, 0, 0, 0, 0);
    tag = "R3"; tick(); tick(); tick();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); errors++; checks++; $display("FAIL watchdog: done=0 expected done=1"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule